// File: doc/BRIEF.md
# Sound Register Access Gate

This block sits between a CPU byte bus and the register file of a four-channel sound unit. On every CPU write it decides whether the value travels on to the channel logic, which value travels, and what is kept for readback. The decision depends on a master enable input driven by the sound unit and on a model-select input that picks between an older and a newer behaviour. On reads it returns the stored value with every unused bit forced to one. Unmapped addresses read as all ones.

The block also owns a 16-byte waveform RAM. While the wave channel is idle the CPU reaches the addressed byte. While it is playing, every access is redirected to the byte the channel is reading at that moment. On the older model such an access only works while a readable flag from the channel is set.

Address layout (6-bit offset): master control 0x00; mixer volume 0x01 and mixer panning 0x02; four channel blocks of eight slots at 0x08 (pulse A), 0x10 (pulse B), 0x18 (wave), 0x20 (noise); waveform RAM 0x30–0x3F; every other offset is unmapped.

Top module: `sndgate_top`

## Requirements
- R1: A write to offset 0x00 is always forwarded with the full written value. Only bit 7 is stored, and the low four bits keep their stored value, which is zero after reset. Readback of 0x00 is the stored value ORed with 0x70.
- R2: With `snd_en` high, a write to a mapped register is forwarded with the full value, and the value is stored.
- R3: With `snd_en` low, a write to a mixer or channel register is not forwarded, and its stored value becomes 0x00. This holds on both models except as R4 and R5 state.
- R4: On the older model (`model_legacy`=1) with `snd_en` low, a write to a pulse duty/length register (0x09, 0x11) is forwarded with the value ANDed with 0x3F, and the stored value becomes 0x00.
- R5: On the older model with `snd_en` low, a write to the wave length register (0x19) or the noise length register (0x21) is forwarded with the full value and stored.
- R6: Readback ORs the stored value with a fixed mask for each register:
  - 0x08: 0x80
  - 0x09, 0x11: 0x3F
  - 0x18: 0x7F
  - 0x1A: 0x9F
  - 0x0B, 0x13, 0x19, 0x1B, 0x21: 0xFF
  - 0x0C, 0x14, 0x1C, 0x24: 0xBF
  - 0x01, 0x02, 0x0A, 0x12, 0x22, 0x23: 0x00
- R7: Reads of unmapped offsets return 0xFF, and writes to them raise no strobe.
- R8: While `wave_playing` is low, a write to 0x30+k stores byte k, and a read of 0x30+k returns byte k.
- R9: While `wave_playing` is high, wave RAM reads and writes use byte `wave_pos>>1` whatever the address. This is always the case on the newer model.
- R10: On the older model, while playing and with `wave_readable` low, wave RAM reads return 0xFF and writes are dropped.
- R11: After reset, no strobe is raised, `rd_data` is 0xFF, and all stored registers and wave bytes are zero.
- R12: A forwarded write raises exactly one strobe bit, at the index equal to the offset, for one cycle after the write cycle, with `reg_wdata` valid in that cycle. `rd_data` updates one cycle after `rd_en` and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 6 | Register offset |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| snd_en | input | 1 | Sound master enable |
| model_legacy | input | 1 | 1 selects older-model behaviour |
| wave_playing | input | 1 | Wave channel is playing |
| wave_pos | input | 5 | Wave play position in nibbles |
| wave_readable | input | 1 | Wave RAM currently accessible (older model) |
| rd_data | output | 8 | Registered read data |
| reg_wstb | output | 40 | Per-register write strobe toward the channels |
| reg_wdata | output | 8 | Data accompanying the strobe |

## Verification
The assertions check the following on every cycle:
- the master write always forwards its data;
- the newer model with the enable low never strobes a channel register;
- disabled pulse-length writes on the older model forward only six bits;
- unmapped and blocked wave reads return 0xFF;
- at most one strobe is high, and only after a write;
- read data holds between reads.

The stored readback values need the bench's write-then-read scenarios. These cover clearing while disabled, the per-register masks, the master's kept low nibble, and wave RAM redirection to the play position including dropped writes. A register model carried across a random mix of enable, model and wave states supplies the expected values.

// File: rtl/sndgate_pkg.sv
// Shared layout constants, types and the per-register attribute table for
// the sound register access gate. The layout is fixed by attr_of(); the
// constants below size every array and index in the design.
package sndgate_pkg;

    localparam int ADDR_W      = 6;
    localparam int DATA_W      = 8;
    localparam int NUM_CH      = 4;
    localparam int CH_SLOTS    = 8;
    localparam int CH_BASE     = 8;
    localparam int MIX_LAST    = 2;
    localparam int NREG        = CH_BASE + NUM_CH * CH_SLOTS;
    localparam int WAVE_BASE   = 48;
    localparam int WAVE_BYTES  = 16;
    localparam int WAVE_IDX_W  = $clog2(WAVE_BYTES);
    localparam int WAVE_POS_W  = WAVE_IDX_W + 1;

    localparam int CH_PULSE_A  = 0;
    localparam int CH_PULSE_B  = 1;
    localparam int CH_WAVE     = 2;
    localparam int CH_NOISE    = 3;

    localparam logic [DATA_W-1:0] LEG_LEN_MASK = 8'h3F;
    localparam logic [DATA_W-1:0] ALL_ONES     = 8'hFF;

    // Access class of an address.
    typedef enum logic [1:0] {
        K_NONE = 2'd0,
        K_REG  = 2'd1,
        K_WAVE = 2'd2
    } acc_kind_e;

    // Write policy while the master enable is off.
    typedef enum logic [1:0] {
        WP_GATED      = 2'd0,
        WP_ALWAYS     = 2'd1,
        WP_LEG_MASKED = 2'd2,
        WP_LEG_PASS   = 2'd3
    } wpol_e;

    typedef struct packed {
        logic              mapped;
        wpol_e             pol;
        logic [DATA_W-1:0] rmask;
    } regattr_t;

    // Attributes of register index idx; unmapped for anything outside the map.
    function automatic regattr_t attr_of(input int idx);
        regattr_t r;
        int ch;
        int slot;
        r = '{1'b0, WP_GATED, ALL_ONES};
        if (idx == 0) begin
            r = '{1'b1, WP_ALWAYS, 8'h70};
        end else if (idx < CH_BASE) begin
            if (idx <= MIX_LAST) r = '{1'b1, WP_GATED, 8'h00};
        end else if (idx < NREG) begin
            ch   = (idx - CH_BASE) / CH_SLOTS;
            slot = (idx - CH_BASE) % CH_SLOTS;
            case (slot)
                0: begin
                    if (ch == CH_PULSE_A) r = '{1'b1, WP_GATED, 8'h80};
                    else if (ch == CH_WAVE) r = '{1'b1, WP_GATED, 8'h7F};
                end
                1: begin
                    if (ch == CH_PULSE_A || ch == CH_PULSE_B)
                        r = '{1'b1, WP_LEG_MASKED, 8'h3F};
                    else
                        r = '{1'b1, WP_LEG_PASS, 8'hFF};
                end
                2: begin
                    if (ch == CH_WAVE) r = '{1'b1, WP_GATED, 8'h9F};
                    else r = '{1'b1, WP_GATED, 8'h00};
                end
                3: begin
                    if (ch == CH_NOISE) r = '{1'b1, WP_GATED, 8'h00};
                    else r = '{1'b1, WP_GATED, 8'hFF};
                end
                4: r = '{1'b1, WP_GATED, 8'hBF};
                default: r = '{1'b0, WP_GATED, ALL_ONES};
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/sndgate_decode.sv
// Address decoder: classifies an offset as register, wave RAM or unmapped,
// and returns the register attributes. Assumes wave RAM base is aligned to
// its size so the low address bits index it directly.
module sndgate_decode
    import sndgate_pkg::*;
(
    input  logic [ADDR_W-1:0]     addr,
    output acc_kind_e             kind,
    output regattr_t              attr,
    output logic [WAVE_IDX_W-1:0] wave_idx
);

    // Classify the address and look up its attributes.
    always_comb begin
        attr     = attr_of(int'(addr));
        wave_idx = addr[WAVE_IDX_W-1:0];
        kind     = K_NONE;
        if (int'(addr) >= WAVE_BASE && int'(addr) < WAVE_BASE + WAVE_BYTES)
            kind = K_WAVE;
        else if (attr.mapped)
            kind = K_REG;
    end

endmodule

// File: rtl/sndgate_wpolicy.sv
// Write policy: for the addressed register decides whether the write is
// forwarded, the forwarded value and the value kept for readback.
// Purely combinational; assumes cur_val is the current stored value.
module sndgate_wpolicy
    import sndgate_pkg::*;
(
    input  wpol_e             pol,
    input  logic              snd_en,
    input  logic              model_legacy,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] cur_val,
    output logic              fwd,
    output logic [DATA_W-1:0] fwd_data,
    output logic [DATA_W-1:0] store_data
);

    // Select forward flag, forward data and stored value by policy.
    always_comb begin
        fwd        = 1'b0;
        fwd_data   = wdata;
        store_data = '0;
        case (pol)
            WP_ALWAYS: begin
                fwd        = 1'b1;
                store_data = {wdata[DATA_W-1], 3'b000, cur_val[3:0]};
            end
            WP_GATED: begin
                if (snd_en) begin
                    fwd        = 1'b1;
                    store_data = wdata;
                end
            end
            WP_LEG_MASKED: begin
                if (snd_en) begin
                    fwd        = 1'b1;
                    store_data = wdata;
                end else if (model_legacy) begin
                    fwd      = 1'b1;
                    fwd_data = wdata & LEG_LEN_MASK;
                end
            end
            WP_LEG_PASS: begin
                if (snd_en || model_legacy) begin
                    fwd        = 1'b1;
                    store_data = wdata;
                end
            end
            default: fwd = 1'b0;
        endcase
    end

endmodule

// File: rtl/sndgate_regfile.sv
// Readback storage: one byte per mapped register index, generated from the
// attribute table; unmapped indices hold constant zero. Assumes wr_sel is
// asserted only for mapped register writes.
module sndgate_regfile
    import sndgate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic [ADDR_W-1:0] idx,
    input  logic [DATA_W-1:0] store_data,
    output logic [DATA_W-1:0] cur_val
);

    logic [DATA_W-1:0] regs [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam regattr_t A = attr_of(i);
        if (A.mapped) begin : g_store
            logic [DATA_W-1:0] q;
            // Hold the readback byte of register i.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (wr_sel && int'(idx) == i)
                    q <= store_data;
            end
            assign regs[i] = q;
        end else begin : g_empty
            assign regs[i] = '0;
        end
    end

    // Select the addressed stored byte.
    always_comb begin
        cur_val = '0;
        if (int'(idx) < NREG) cur_val = regs[idx];
    end

endmodule

// File: rtl/sndgate_wave.sv
// Waveform RAM with play-position arbitration: idle channel uses the
// addressed byte; a playing channel redirects to byte pos>>1, and the older
// model blocks access unless the readable flag is set.
module sndgate_wave
    import sndgate_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic [WAVE_IDX_W-1:0] idx,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  playing,
    input  logic                  model_legacy,
    input  logic                  readable,
    input  logic [WAVE_POS_W-1:0] pos,
    output logic [DATA_W-1:0]     rdata
);

    logic [DATA_W-1:0]     mem [WAVE_BYTES];
    logic [WAVE_IDX_W-1:0] tgt;
    logic                  blocked;

    // Pick the target byte and whether the CPU is locked out.
    always_comb begin
        tgt     = playing ? pos[WAVE_POS_W-1:1] : idx;
        blocked = playing && model_legacy && !readable;
    end

    for (genvar b = 0; b < WAVE_BYTES; b++) begin : g_byte
        // Store one wave byte.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[b] <= '0;
            else if (wr && !blocked && int'(tgt) == b)
                mem[b] <= wdata;
        end
    end

    // Return the target byte, or all ones while locked out.
    always_comb begin
        rdata = blocked ? ALL_ONES : mem[tgt];
    end

endmodule

// File: rtl/sndgate_top.sv
// Sound register access gate top: decodes CPU accesses, applies the
// enable/model write policy, keeps readback state and wave RAM, and
// registers the read data and the per-register strobes. Assumes a single
// clock domain and at most one access per cycle on addr.
module sndgate_top
    import sndgate_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  rd_en,
    input  logic                  wr_en,
    input  logic                  snd_en,
    input  logic                  model_legacy,
    input  logic                  wave_playing,
    input  logic [WAVE_POS_W-1:0] wave_pos,
    input  logic                  wave_readable,
    output logic [DATA_W-1:0]     rd_data,
    output logic [NREG-1:0]       reg_wstb,
    output logic [DATA_W-1:0]     reg_wdata
);

    acc_kind_e             kind;
    regattr_t              attr;
    logic [WAVE_IDX_W-1:0] wave_idx;
    logic                  fwd;
    logic [DATA_W-1:0]     fwd_data;
    logic [DATA_W-1:0]     store_data;
    logic [DATA_W-1:0]     cur_val;
    logic [DATA_W-1:0]     wave_rd;
    logic                  reg_wr;
    logic [DATA_W-1:0]     rd_next;

    sndgate_decode u_decode (
        .addr     (addr),
        .kind     (kind),
        .attr     (attr),
        .wave_idx (wave_idx)
    );

    sndgate_wpolicy u_policy (
        .pol          (attr.pol),
        .snd_en       (snd_en),
        .model_legacy (model_legacy),
        .wdata        (wr_data),
        .cur_val      (cur_val),
        .fwd          (fwd),
        .fwd_data     (fwd_data),
        .store_data   (store_data)
    );

    sndgate_regfile u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_sel     (reg_wr),
        .idx        (addr),
        .store_data (store_data),
        .cur_val    (cur_val)
    );

    sndgate_wave u_wave (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr           (wr_en && kind == K_WAVE),
        .idx          (wave_idx),
        .wdata        (wr_data),
        .playing      (wave_playing),
        .model_legacy (model_legacy),
        .readable     (wave_readable),
        .pos          (wave_pos),
        .rdata        (wave_rd)
    );

    // Register write qualifier.
    assign reg_wr = wr_en && kind == K_REG;

    // Read-side value for the current address.
    always_comb begin
        case (kind)
            K_REG:   rd_next = cur_val | attr.rmask;
            K_WAVE:  rd_next = wave_rd;
            default: rd_next = ALL_ONES;
        endcase
    end

    // One-cycle strobe and its data toward the channels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_wstb  <= '0;
            reg_wdata <= '0;
        end else begin
            reg_wstb <= '0;
            if (reg_wr && fwd) begin
                reg_wstb[addr] <= 1'b1;
                reg_wdata      <= fwd_data;
            end
        end
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= ALL_ONES;
        else if (rd_en)
            rd_data <= rd_next;
    end

endmodule

// File: rtl/sndgate_checker.sv
// Cycle properties of the sound register access gate, bound to the top.
module sndgate_checker
    import sndgate_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic [ADDR_W-1:0]     addr,
    input logic [DATA_W-1:0]     wr_data,
    input logic                  rd_en,
    input logic                  wr_en,
    input logic                  snd_en,
    input logic                  model_legacy,
    input logic                  wave_playing,
    input logic                  wave_readable,
    input logic [DATA_W-1:0]     rd_data,
    input logic [NREG-1:0]       reg_wstb,
    input logic [DATA_W-1:0]     reg_wdata
);

    p_master_fwd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == '0) |=> (reg_wstb[0] && reg_wdata == $past(wr_data)));

    p_gate_newer_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !snd_en && !model_legacy && addr != '0) |=> (reg_wstb == '0));

    p_legacy_duty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !snd_en && model_legacy && (addr == 6'h09 || addr == 6'h11))
        |=> (reg_wstb != '0 && reg_wdata == ($past(wr_data) & LEG_LEN_MASK)));

    p_unmapped_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr >= 6'h03 && addr < 6'h08) |=> (rd_data == ALL_ONES));

    p_wave_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr >= 6'(WAVE_BASE) && wave_playing && model_legacy && !wave_readable)
        |=> (rd_data == ALL_ONES));

    p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reg_wstb));

    p_strobe_needs_wr_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (reg_wstb == '0));

    p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

bind sndgate_top sndgate_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .addr          (addr),
    .wr_data       (wr_data),
    .rd_en         (rd_en),
    .wr_en         (wr_en),
    .snd_en        (snd_en),
    .model_legacy  (model_legacy),
    .wave_playing  (wave_playing),
    .wave_readable (wave_readable),
    .rd_data       (rd_data),
    .reg_wstb      (reg_wstb),
    .reg_wdata     (reg_wdata)
);

// File: tb/sndgate_top_bench.sv
`timescale 1ns/1ps
module sndgate_top_bench;
    import sndgate_pkg::*;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [ADDR_W-1:0]     addr = '0;
    logic [DATA_W-1:0]     wr_data = '0;
    logic                  rd_en = 1'b0;
    logic                  wr_en = 1'b0;
    logic                  snd_en = 1'b0;
    logic                  model_legacy = 1'b0;
    logic                  wave_playing = 1'b0;
    logic [WAVE_POS_W-1:0] wave_pos = '0;
    logic                  wave_readable = 1'b0;
    logic [DATA_W-1:0]     rd_data;
    logic [NREG-1:0]       reg_wstb;
    logic [DATA_W-1:0]     reg_wdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] mstore [64];
    logic [7:0] mwave  [16];

    always #2.5 clk = ~clk;

    sndgate_top u_sndgate_top (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data),
        .rd_en(rd_en), .wr_en(wr_en), .snd_en(snd_en),
        .model_legacy(model_legacy), .wave_playing(wave_playing),
        .wave_pos(wave_pos), .wave_readable(wave_readable),
        .rd_data(rd_data), .reg_wstb(reg_wstb), .reg_wdata(reg_wdata)
    );

    // Readback mask from R6/R1; bit 8 set means mapped.
    function automatic logic [8:0] bmask(input int a);
        case (a)
            0: return 9'h170;
            1, 2, 10, 18, 34, 35: return 9'h100;
            8: return 9'h180;
            9, 17: return 9'h13F;
            11, 19, 25, 27, 33: return 9'h1FF;
            12, 20, 28, 36: return 9'h1BF;
            24: return 9'h17F;
            26: return 9'h19F;
            default: return 9'h0FF;
        endcase
    endfunction

    function automatic bit is_wave(input int a);
        return a >= 48;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input int a, input logic [7:0] d);
        logic [8:0] m;
        bit fwd;
        logic [7:0] fd;
        string req;
        int t;
        @(negedge clk);
        addr = 6'(a); wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        m = bmask(a); fwd = 0; fd = d; req = "R7";
        if (is_wave(a)) begin
            req = "R8";
            t = wave_playing ? int'(wave_pos >> 1) : a - 48;
            if (wave_playing && model_legacy && !wave_readable) req = "R10";
            else mwave[t] = d;
        end else if (m[8]) begin
            if (a == 0) begin
                req = "R1"; fwd = 1; mstore[0] = {d[7], 3'b000, mstore[0][3:0]};
            end else if (snd_en) begin
                req = "R2"; fwd = 1; mstore[a] = d;
            end else if (model_legacy && (a == 9 || a == 17)) begin
                req = "R4"; fwd = 1; fd = d & 8'h3F; mstore[a] = 0;
            end else if (model_legacy && (a == 25 || a == 33)) begin
                req = "R5"; fwd = 1; mstore[a] = d;
            end else begin
                req = "R3"; mstore[a] = 0;
            end
        end
        chk(reg_wstb == (fwd ? (NREG'(1) << a) : '0), req, 64'(reg_wstb), fwd ? (64'd1 << a) : 64'd0);
        if (fwd) chk(reg_wdata == fd, req, 64'(reg_wdata), 64'(fd));
    endtask

    task automatic do_read(input int a, input string req);
        logic [8:0] m;
        logic [7:0] e;
        @(negedge clk);
        addr = 6'(a); rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        m = bmask(a);
        if (is_wave(a)) begin
            if (wave_playing && model_legacy && !wave_readable) e = 8'hFF;
            else e = wave_playing ? mwave[wave_pos >> 1] : mwave[a - 48];
        end else if (m[8]) e = mstore[a] | m[7:0];
        else e = 8'hFF;
        chk(rd_data == e, req, 64'(rd_data), 64'(e));
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        int s;
        logic [7:0] hold;
        s = $urandom(32'h5EED);
        for (int i = 0; i < 64; i++) mstore[i] = 0;
        for (int i = 0; i < 16; i++) mwave[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(reg_wstb == '0, "R11", 64'(reg_wstb), 0);
        chk(rd_data == 8'hFF, "R11", 64'(rd_data), 64'hFF);
        do_read(0, "R11");
        do_read(48, "R11");
        // R1 master keeps only bit 7, disabled or not
        do_write(0, 8'h0F); do_read(0, "R1");
        do_write(0, 8'hFF); do_read(0, "R1");
        // R2 and R6 enabled writes with masks
        snd_en = 1'b1;
        do_write(10, 8'hA5); do_read(10, "R6");
        do_write(26, 8'h40); do_read(26, "R6");
        do_write(8, 8'h12); do_read(8, "R6");
        // R3 newer model disabled clears storage
        snd_en = 1'b0;
        do_write(10, 8'h5A); do_read(10, "R3");
        // R4 and R5 on the older model
        model_legacy = 1'b1;
        do_write(9, 8'hFF); do_read(9, "R4");
        do_write(33, 8'h77);
        // R7 unmapped
        do_write(5, 8'h33); do_read(5, "R7"); do_read(42, "R7");
        // R8 idle wave, R9 playing redirect, R10 blocked
        do_write(50, 8'hC3); do_read(50, "R8");
        wave_playing = 1'b1; wave_pos = 5'd5; wave_readable = 1'b1;
        do_read(60, "R9");
        do_write(61, 8'h9E); do_read(49, "R9");
        wave_readable = 1'b0;
        do_write(49, 8'h11); do_read(49, "R10");
        wave_readable = 1'b1; do_read(49, "R10");
        wave_playing = 1'b0;
        // R12 hold and single-cycle strobe
        do_write(12, 8'h01);
        hold = rd_data;
        @(negedge clk);
        chk(reg_wstb == '0, "R12", 64'(reg_wstb), 0);
        chk(rd_data == hold, "R12", 64'(rd_data), 64'(hold));
        // Random mix
        for (int i = 0; i < 800; i++) begin
            int a;
            snd_en        = 1'($urandom);
            model_legacy  = 1'($urandom);
            wave_playing  = ($urandom % 4) == 0;
            wave_pos      = 5'($urandom);
            wave_readable = 1'($urandom);
            a = int'($urandom % 64);
            do_write(a, 8'($urandom));
            do_read(a, "R2");
            do_read(int'($urandom % 64), "R6");
        end
        finish_run();
    end

endmodule